// File: doc/BRIEF.md
# Multi-slot conversion pending scheduler

This block arbitrates a single shared analog-to-digital converter among a set of sample slots. Each slot can be triggered by a hardware pulse on its bit of `trig_i` or by a software write of a slot mask. A triggered slot is marked pending. While the converter is idle, the scheduler grants it to the lowest-numbered pending slot. It issues a one-cycle start strobe and then waits for the converter's done strobe. The block then captures the result into the slot's result word and drops that slot's pending bit.

Software can also clear queued requests with a cancel write. It can clear per-slot trigger overrun flags with a write of ones. Each slot's result word can be read through a slot-select port, and a read strobe clears that slot's valid and data overrun flags. Summary outputs OR together the per-slot valid, data overrun and trigger overrun flags. A busy output is high while a conversion is in progress.

Top module: `conv_sched`

## Requirements
- R1: After reset all pending, valid, data overrun and trigger overrun flags are 0, `busy_o` is 0 and `conv_start` is 0.
- R2: A write with `wr_sel`=0 sets the pending bit of every slot whose `wr_data` bit is 1, and a 1 on `trig_i[n]` sets pending bit n. The new pending bits are visible on `pending_o` after the clock edge at which the stimulus is sampled.
- R3: While `busy_o` is 0 and any slot is pending, `conv_start` is 1 in the same cycle and `conv_slot` names the lowest-numbered pending slot. `busy_o` is 1 from the next edge until the edge that samples `conv_done`.
- R4: At an edge where `busy_o` is 1 and `conv_done` is 1, the granted slot's result word becomes {valid=1, overrun, `conv_result`}. Its pending bit goes to 0 and `busy_o` goes to 0.
- R5: A write with `wr_sel`=1 clears the pending bit of each slot marked 1 in `wr_data`, except the slot being converted, whose pending bit is unaffected.
- R6: A trigger of either kind on a slot that is already pending leaves `pending_o` unchanged and sets that slot's bit of `trig_ovf_o`. A write with `wr_sel`=2 clears each `trig_ovf_o` bit marked 1 in `wr_data`. A set in the same cycle wins over the clear.
- R7: `rd_word` shows the selected slot's word combinationally: bits [15:0] hold the result, bit 16 the data overrun flag and bit 17 the valid flag. A `rd_en` strobe clears that slot's valid and overrun flags at the edge. A result that lands while the slot's valid flag is 1, with no read in that cycle, sets the overrun flag.
- R8: `any_valid`, `any_dovr` and `any_tovf` are 1 exactly when at least one slot has its valid, data overrun or trigger overrun flag set, respectively.
- R9: `conv_done` while `busy_o` is 0 changes no result word and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trig_i | input | NSLOT | Hardware trigger pulses, one per slot |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 trigger, 1 cancel pending, 2 clear trigger overrun, 3 none |
| wr_data | input | NSLOT | Slot mask for the write |
| rd_en | input | 1 | Read strobe, clears the selected slot's valid and overrun flags |
| rd_slot | input | SW | Slot selected for reading |
| rd_word | output | DW+2 | {valid, overrun, result} of the selected slot |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_slot | output | SW | Slot being started or converted |
| conv_done | input | 1 | Converter end-of-conversion strobe |
| conv_result | input | DW | Converter result, sampled with conv_done |
| pending_o | output | NSLOT | Pending bit per slot |
| trig_ovf_o | output | NSLOT | Trigger overrun flag per slot |
| busy_o | output | 1 | Conversion in progress |
| any_valid | output | 1 | OR of all valid flags |
| any_dovr | output | 1 | OR of all data overrun flags |
| any_tovf | output | 1 | OR of all trigger overrun flags |

## Verification
A write or trigger sampled at one edge shows on `pending_o`, and if the block is idle on `conv_start`/`conv_slot`, in the cycle right after that edge. `busy_o` rises one edge after the start strobe. A done strobe sampled at an edge updates `rd_word`, the pending bit, `busy_o` and the summaries after that same edge, and a read clears its flags one edge after the strobe. The bench drives inputs and samples outputs at falling edges, so every check lands in the first cycle where its result is due. Each slot is swept on its own, then all slots are queued at once so that the order of the grants can be checked.

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int NSLOT = 19,
  parameter int DW    = 16,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] trig_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [NSLOT-1:0] wr_data,
  input  logic             rd_en,
  input  logic [SW-1:0]    rd_slot,
  output logic [DW+1:0]    rd_word,
  output logic             conv_start,
  output logic [SW-1:0]    conv_slot,
  input  logic             conv_done,
  input  logic [DW-1:0]    conv_result,
  output logic [NSLOT-1:0] pending_o,
  output logic [NSLOT-1:0] trig_ovf_o,
  output logic             busy_o,
  output logic             any_valid,
  output logic             any_dovr,
  output logic             any_tovf
);
  localparam logic [NSLOT-1:0] ONE = NSLOT'(1);

  logic [NSLOT-1:0] pend, tovf, valid, dovr;
  logic [DW-1:0]    data [NSLOT];
  logic             busy;
  logic [SW-1:0]    act;
  logic [SW-1:0]    pick;

  logic [NSLOT-1:0] set_vec, cancel_vec, tclr_vec, done_vec, rd_vec, act_vec;
  logic             done_hit;

  assign act_vec    = busy ? (ONE << act) : '0;
  assign set_vec    = trig_i | ((wr_en && wr_sel == 2'd0) ? wr_data : '0);
  assign cancel_vec = (wr_en && wr_sel == 2'd1) ? (wr_data & ~act_vec) : '0;
  assign tclr_vec   = (wr_en && wr_sel == 2'd2) ? wr_data : '0;
  assign done_hit   = busy && conv_done;
  assign done_vec   = done_hit ? act_vec : '0;
  assign rd_vec     = (rd_en && rd_slot < SW'(NSLOT)) ? (ONE << rd_slot) : '0;

  always_comb begin
    pick = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (pend[i]) pick = SW'(i);
  end

  assign conv_start = !busy && (|pend);
  assign conv_slot  = busy ? act : pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      tovf  <= '0;
      valid <= '0;
      dovr  <= '0;
      busy  <= 1'b0;
      act   <= '0;
    end else begin
      pend  <= (pend & ~cancel_vec & ~done_vec) | (set_vec & ~pend);
      tovf  <= (tovf & ~tclr_vec) | (set_vec & pend);
      valid <= (valid & ~rd_vec) | done_vec;
      dovr  <= (dovr & ~rd_vec) | (done_vec & valid & ~rd_vec);
      if (conv_start) begin
        busy <= 1'b1;
        act  <= pick;
      end else if (done_hit) begin
        busy <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              data[g] <= '0;
      else if (done_vec[g])    data[g] <= conv_result;
    end
  end

  assign rd_word    = (rd_slot < SW'(NSLOT)) ? {valid[rd_slot], dovr[rd_slot], data[rd_slot]} : '0;
  assign pending_o  = pend;
  assign trig_ovf_o = tovf;
  assign busy_o     = busy;
  assign any_valid  = |valid;
  assign any_dovr   = |dovr;
  assign any_tovf   = |tovf;

  assert_lowest_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (pending_o[conv_slot] && ((pending_o & ((ONE << conv_slot) - ONE)) == '0)));

  assert_busy_follows_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> busy_o);

  assert_result_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && conv_done) |=> (valid[$past(act)] && !pending_o[$past(act)] && !busy_o));

  assert_trig_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(trig_i & pending_o)) |=> ((trig_ovf_o & $past(trig_i & pending_o)) == $past(trig_i & pending_o)));

  assert_idle_done_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && conv_done && !rd_en) |=> ($stable(valid) && $stable(dovr)));
endmodule

// File: tb/conv_sched_bench.sv
module conv_sched_bench;
  localparam int NSLOT = 19;
  localparam int DW    = 16;
  localparam int SW    = $clog2(NSLOT);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSLOT-1:0] trig_i = '0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = 2'd3;
  logic [NSLOT-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [SW-1:0]    rd_slot = '0;
  logic [DW+1:0]    rd_word;
  logic             conv_start;
  logic [SW-1:0]    conv_slot;
  logic             conv_done = 1'b0;
  logic [DW-1:0]    conv_result = '0;
  logic [NSLOT-1:0] pending_o, trig_ovf_o;
  logic             busy_o, any_valid, any_dovr, any_tovf;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  conv_sched #(.NSLOT(NSLOT), .DW(DW)) u_conv_sched (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_slot(rd_slot), .rd_word(rd_word),
    .conv_start(conv_start), .conv_slot(conv_slot), .conv_done(conv_done),
    .conv_result(conv_result), .pending_o(pending_o), .trig_ovf_o(trig_ovf_o),
    .busy_o(busy_o), .any_valid(any_valid), .any_dovr(any_dovr), .any_tovf(any_tovf)
  );

  function automatic logic [DW-1:0] res_of(int s, int k);
    return DW'((s * 16'h0d0b + k * 16'h1111 + 7) & 16'hffff);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] sel, logic [NSLOT-1:0] mask);
    wr_en = 1'b1; wr_sel = sel; wr_data = mask;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic finish_conv(logic [DW-1:0] res);
    conv_done = 1'b1; conv_result = res;
    @(posedge clk); @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic serve(int s, logic [DW-1:0] res);
    check("R3 start", 64'(conv_start), 64'd1);
    check("R3 slot", 64'(conv_slot), 64'(s));
    @(posedge clk); @(negedge clk);
    check("R3 busy", 64'(busy_o), 64'd1);
    finish_conv(res);
    check("R4 busy low", 64'(busy_o), 64'd0);
    check("R4 pending clear", 64'(pending_o[s]), 64'd0);
  endtask

  task automatic do_read(int s);
    rd_slot = SW'(s); rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pending", 64'(pending_o), 64'd0);
    check("R1 busy", 64'(busy_o), 64'd0);
    check("R1 start", 64'(conv_start), 64'd0);
    check("R1 summaries", {61'd0, any_valid, any_dovr, any_tovf}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep every slot alone
    for (int s = 0; s < NSLOT; s++) begin
      do_write(2'd0, NSLOT'(1) << s);
      check("R2 pending set", 64'(pending_o), 64'(NSLOT'(1) << s));
      serve(s, res_of(s, 0));
      rd_slot = SW'(s);
      #1;
      check("R7 word", 64'(rd_word), 64'({2'b10, res_of(s, 0)}));
      check("R8 any_valid", 64'(any_valid), 64'd1);
      do_read(s);
      #1;
      check("R7 read clears", 64'(rd_word[DW+1:DW]), 64'd0);
      check("R8 any_valid low", 64'(any_valid), 64'd0);
    end

    // all slots at once: lowest first
    do_write(2'd0, {NSLOT{1'b1}});
    check("R2 all pending", 64'(pending_o), 64'({NSLOT{1'b1}}));
    for (int s = 0; s < NSLOT; s++) serve(s, res_of(s, 1));
    check("R3 no start when empty", 64'(conv_start), 64'd0);
    for (int s = 0; s < NSLOT; s++) begin
      rd_slot = SW'(s);
      #1;
      check("R4 stored word", 64'(rd_word), 64'({2'b10, res_of(s, 1)}));
    end

    // data overrun on slot 3
    do_write(2'd0, NSLOT'(1) << 3);
    serve(3, res_of(3, 2));
    rd_slot = SW'(3);
    #1;
    check("R7 overrun word", 64'(rd_word), 64'({2'b11, res_of(3, 2)}));
    check("R8 any_dovr", 64'(any_dovr), 64'd1);
    do_read(3);
    check("R8 any_dovr low", 64'(any_dovr), 64'd0);
    check("R8 any_valid others", 64'(any_valid), 64'd1);
    for (int s = 0; s < NSLOT; s++) if (s != 3) do_read(s);
    check("R8 all read", 64'(any_valid), 64'd0);

    // trigger overrun via hardware trigger
    trig_i = NSLOT'(1) << 5;
    @(posedge clk); @(negedge clk);
    trig_i = '0;
    check("R6 first trigger pending", 64'(pending_o), 64'(NSLOT'(1) << 5));
    check("R6 no overrun yet", 64'(trig_ovf_o), 64'd0);
    @(posedge clk); @(negedge clk);
    trig_i = NSLOT'(1) << 5;
    @(posedge clk); @(negedge clk);
    trig_i = '0;
    check("R6 overrun flag", 64'(trig_ovf_o), 64'(NSLOT'(1) << 5));
    check("R6 pending unchanged", 64'(pending_o), 64'(NSLOT'(1) << 5));
    check("R8 any_tovf", 64'(any_tovf), 64'd1);
    do_write(2'd2, NSLOT'(1) << 5);
    check("R6 overrun cleared", 64'(trig_ovf_o), 64'd0);
    check("R8 any_tovf low", 64'(any_tovf), 64'd0);
    finish_conv(res_of(5, 3));
    check("R4 slot5 done", 64'(pending_o), 64'd0);
    do_read(5);

    // cancel: active slot kept, queued removed
    do_write(2'd0, NSLOT'(1));
    check("R3 start slot0", 64'(conv_slot), 64'd0);
    do_write(2'd0, NSLOT'(6));
    check("R2 queued", 64'(pending_o), 64'd7);
    do_write(2'd1, NSLOT'(7));
    check("R5 cancel", 64'(pending_o), 64'd1);
    check("R5 still busy", 64'(busy_o), 64'd1);
    finish_conv(res_of(0, 4));
    check("R5 nothing left", 64'(pending_o), 64'd0);
    check("R5 no restart", 64'(conv_start), 64'd0);
    rd_slot = SW'(0);
    #1;
    check("R5 active result", 64'(rd_word), 64'({2'b10, res_of(0, 4)}));

    // done while idle is ignored
    finish_conv(16'hbeef);
    rd_slot = SW'(0);
    #1;
    check("R9 word kept", 64'(rd_word), 64'({2'b10, res_of(0, 4)}));
    rd_slot = SW'(1);
    #1;
    check("R9 other slot kept", 64'(rd_word), 64'({2'b00, res_of(1, 1)}));
    check("R9 busy low", 64'(busy_o), 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule